// File: doc/BRIEF.md
# Decimal Matrix Memory ECC Codec

This block guards one 32-bit memory word with 36 redundant bits. It treats the word as two 16-bit rows, and each row as four 4-bit symbols. Each row has two row checks. A row check is the 5-bit arithmetic sum of a pair of symbols, so the carry is kept. There is also a 16-bit column check, which is the XOR of the two rows. The same check generator serves both directions. When storing a word, the codec emits the check bits. When fetching a word, it recomputes the checks from the fetched data and compares them with the stored checks to form syndromes. It then repairs the data when the damage can be placed in a single row.

A 2-bit operation code picks the operation for the cycle: store, fetch, or idle. Results are registered. A valid strobe marks the cycle in which a result appears. The codec sits between a memory controller and the storage array. On a store, the controller writes the data and the check output into the array. On a fetch, it feeds both back in.

Top module: `dmcCodec`

## Requirements
- R1: In store mode (`opMode` = 01), `chkOut[19:0]` holds four 5-bit row-check fields. Field k = 2r+p sits at bits [5k+4:5k] and equals symbol p plus symbol p+2 of row r. Row r is `dataIn[16r+15:16r]`, and symbol s of a row is its bits [4s+3:4s]. In the same mode, `chkOut[35:20]` equals row 0 XOR row 1.
- R2: In store mode, `dataOut` equals `dataIn`, and `errFlag` and `uncFlag` are both low.
- R3: In fetch mode (`opMode` = 10), clean data with matching checks gives `dataOut` equal to `dataIn`, an all-zero `chkOut`, and both flags low.
- R4: In fetch mode, each row-check field of `chkOut` carries the stored field minus the recomputed sum, modulo 32. `chkOut[35:20]` carries the stored column check XOR the recomputed one. `errFlag` is high whenever any syndrome bit is nonzero.
- R5: A row is flagged when either of its two row-check syndromes is nonzero. If exactly one row is flagged and the column syndrome is nonzero, that row of `dataOut` is the fetched row XOR the column syndrome. The other row passes through unchanged, and `uncFlag` is low.
- R6: If the column syndrome is nonzero and either no row or both rows are flagged, `uncFlag` and `errFlag` are high and `dataOut` equals `dataIn`. This covers bit flips whose sums cancel within one row.
- R7: If one or more rows are flagged but the column syndrome is zero, `errFlag` is high, `uncFlag` is low, and `dataOut` equals `dataIn`.
- R8: Operation codes 00 and 11 are idle. In the cycle after an idle code, `validOut`, `errFlag` and `uncFlag` are low, and `dataOut` and `chkOut` keep their previous values.
- R9: A store or fetch result appears on the outputs one clock edge after the operation code is sampled. `validOut` is high in exactly that cycle.
- R10: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opMode | input | 2 | 01 store, 10 fetch, 00/11 idle |
| dataIn | input | 32 | Data word to store, or fetched word |
| chkIn | input | 36 | Stored check bits (used in fetch mode) |
| dataOut | output | 32 | Passed-through or corrected data |
| chkOut | output | 36 | Check bits (store) or syndromes (fetch) |
| validOut | output | 1 | Result valid strobe |
| errFlag | output | 1 | Mismatch seen on fetch |
| uncFlag | output | 1 | Mismatch cannot be repaired |

## Verification
Every store and fetch result is due exactly one rising edge after the operation is applied. The driver applies inputs on a falling edge and queues the expected result at the same time. The monitor pops and compares that result on the next falling edge, but only when `validOut` is high, so a result that arrives early, late, or never shows up as a queue mismatch. Idle behaviour is checked on the falling edge that follows the idle code. At that point the strobe and both flags must be low and the held outputs must match the last queued result.

// File: rtl/dmcPkg.sv
package dmcPkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_STORE = 2'b01,
    OP_FETCH = 2'b10,
    OP_HOLD  = 2'b11
  } opCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doStore;
    logic doFetch;
    logic doIdle;
  } ctrlStrobes_t;
endpackage

// File: rtl/dmcCheckGen.sv
// Shared check generator: pairwise symbol sums per row, column XOR over rows.
module dmcCheckGen #(
  parameter int ROWS = 2,
  parameter int SYMS = 4,
  parameter int SYMW = 4,
  localparam int ROWW  = SYMS * SYMW,
  localparam int DATAW = ROWS * ROWW,
  localparam int PAIRS = SYMS / 2,
  localparam int SUMW  = SYMW + 1,
  localparam int HW    = ROWS * PAIRS * SUMW
) (
  input  logic [DATAW-1:0] dataIn,
  output logic [HW-1:0]    hGen,
  output logic [ROWW-1:0]  vGen
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign hGen[(r*PAIRS+p)*SUMW +: SUMW] =
        SUMW'(dataIn[r*ROWW + p*SYMW +: SYMW]) +
        SUMW'(dataIn[r*ROWW + (p+PAIRS)*SYMW +: SYMW]);
    end
  end

  always_comb begin
    vGen = '0;
    for (int r = 0; r < ROWS; r++) vGen = vGen ^ dataIn[r*ROWW +: ROWW];
  end
endmodule

// File: rtl/dmcCtrl.sv
module dmcCtrl
  import dmcPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   opMode,
  output ctrlStrobes_t strobes,
  output logic         validOut
);
  always_comb begin
    strobes = '0;
    unique case (opMode)
      OP_STORE: strobes.doStore = 1'b1;
      OP_FETCH: strobes.doFetch = 1'b1;
      default:  strobes.doIdle  = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= strobes.doStore | strobes.doFetch;
  end

  // R9: an idle code is never followed by a valid strobe
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opMode) == 2'b00 || $past(opMode) == 2'b11) |-> !validOut);
endmodule

// File: rtl/dmcDatapath.sv
module dmcDatapath
  import dmcPkg::*;
#(
  parameter int ROWS = 2,
  parameter int SYMS = 4,
  parameter int SYMW = 4,
  localparam int ROWW  = SYMS * SYMW,
  localparam int DATAW = ROWS * ROWW,
  localparam int PAIRS = SYMS / 2,
  localparam int SUMW  = SYMW + 1,
  localparam int HW    = ROWS * PAIRS * SUMW,
  localparam int CHKW  = HW + ROWW
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [DATAW-1:0] dataIn,
  input  logic [CHKW-1:0]  chkIn,
  output logic [DATAW-1:0] dataOut,
  output logic [CHKW-1:0]  chkOut,
  output logic             errFlag,
  output logic             uncFlag
);
  logic [HW-1:0]    hGen, hSyn;
  logic [ROWW-1:0]  vGen, vSyn;
  logic [ROWS-1:0]  rowFlag;
  logic [DATAW-1:0] corrData;
  logic             oneRow, errAny, uncAny;

  dmcCheckGen #(.ROWS(ROWS), .SYMS(SYMS), .SYMW(SYMW)) u_gen (
    .dataIn(dataIn), .hGen(hGen), .vGen(vGen)
  );

  assign vSyn   = chkIn[CHKW-1 -: ROWW] ^ vGen;
  assign oneRow = $onehot(rowFlag);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      localparam int IDX = (r*PAIRS + p) * SUMW;
      assign hSyn[IDX +: SUMW] = chkIn[IDX +: SUMW] - hGen[IDX +: SUMW];
    end
    assign rowFlag[r] = |hSyn[r*PAIRS*SUMW +: PAIRS*SUMW];
    assign corrData[r*ROWW +: ROWW] = dataIn[r*ROWW +: ROWW] ^
      ((rowFlag[r] && oneRow) ? vSyn : '0);
  end

  assign errAny = (|hSyn) | (|vSyn);
  assign uncAny = (|vSyn) & ~oneRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      chkOut  <= '0;
      errFlag <= 1'b0;
      uncFlag <= 1'b0;
    end else if (strobes.doStore) begin
      dataOut <= dataIn;
      chkOut  <= {vGen, hGen};
      errFlag <= 1'b0;
      uncFlag <= 1'b0;
    end else if (strobes.doFetch) begin
      dataOut <= uncAny ? dataIn : corrData;
      chkOut  <= {vSyn, hSyn};
      errFlag <= errAny;
      uncFlag <= uncAny;
    end else begin
      errFlag <= 1'b0;
      uncFlag <= 1'b0;
    end
  end

  // R6: an unrepairable word is always also reported as an error
  a_r6_unc_implies_err: assert property (@(posedge clk) disable iff (!rstN)
    uncFlag |-> errFlag);
  // R6: an unrepairable word leaves the data untouched
  a_r6_unc_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    uncFlag |-> dataOut == $past(dataIn));
  // R2: a store never raises a flag
  a_r2_store_clean: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.doStore) |-> (!errFlag && !uncFlag));
  // R8: idle clears both flags
  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.doIdle) |-> (!errFlag && !uncFlag));
endmodule

// File: rtl/dmcCodec.sv
module dmcCodec #(
  parameter int ROWS = 2,
  parameter int SYMS = 4,
  parameter int SYMW = 4,
  localparam int ROWW  = SYMS * SYMW,
  localparam int DATAW = ROWS * ROWW,
  localparam int CHKW  = ROWS * (SYMS / 2) * (SYMW + 1) + ROWW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opMode,
  input  logic [DATAW-1:0] dataIn,
  input  logic [CHKW-1:0]  chkIn,
  output logic [DATAW-1:0] dataOut,
  output logic [CHKW-1:0]  chkOut,
  output logic             validOut,
  output logic             errFlag,
  output logic             uncFlag
);
  dmcPkg::ctrlStrobes_t strobes;

  dmcCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .opMode(opMode),
    .strobes(strobes), .validOut(validOut)
  );

  dmcDatapath #(.ROWS(ROWS), .SYMS(SYMS), .SYMW(SYMW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dataIn(dataIn), .chkIn(chkIn),
    .dataOut(dataOut), .chkOut(chkOut),
    .errFlag(errFlag), .uncFlag(uncFlag)
  );
endmodule

// File: tb/dmcCodec_bench.sv
`timescale 1ns/1ps
module dmcCodec_bench;
  typedef struct packed {
    logic [31:0] d;
    logic [35:0] c;
    logic        e;
    logic        u;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opMode = 2'b00;
  logic [31:0] dataIn = '0;
  logic [35:0] chkIn = '0;
  logic [31:0] dataOut;
  logic [35:0] chkOut;
  logic        validOut, errFlag, uncFlag;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  exp_t last = '0;

  always #2 clk = ~clk;

  dmcCodec u_dmcCodec (
    .clk(clk), .rstN(rstN), .opMode(opMode), .dataIn(dataIn), .chkIn(chkIn),
    .dataOut(dataOut), .chkOut(chkOut), .validOut(validOut),
    .errFlag(errFlag), .uncFlag(uncFlag)
  );

  // reference model written from R1..R7
  function automatic exp_t model(logic [1:0] m, logic [31:0] d, logic [35:0] c);
    exp_t x;
    logic [4:0]  s, f;
    logic [15:0] v, vs;
    logic [19:0] h;
    logic [1:0]  rf;
    logic [31:0] cd;
    v  = d[15:0] ^ d[31:16];
    rf = 2'b00;
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 2; p++) begin
        s = {1'b0, d[16*r + 4*p +: 4]} + {1'b0, d[16*r + 4*(p+2) +: 4]};
        f = c[5*(2*r+p) +: 5] - s;
        h[5*(2*r+p) +: 5] = (m == 2'b01) ? s : f;
        if (f != 5'd0) rf[r] = 1'b1;
      end
    end
    if (m == 2'b01) begin
      x = '{d: d, c: {v, h}, e: 1'b0, u: 1'b0};
    end else begin
      vs = c[35:20] ^ v;
      cd = d;
      if (vs != 16'd0 && rf == 2'b01) cd[15:0]  = d[15:0]  ^ vs;
      if (vs != 16'd0 && rf == 2'b10) cd[31:16] = d[31:16] ^ vs;
      x.d = cd;
      x.c = {vs, h};
      x.e = (h != 20'd0) || (vs != 16'd0);
      x.u = (vs != 16'd0) && (rf == 2'b00 || rf == 2'b11);
    end
    return x;
  endfunction

  function automatic logic [35:0] gen(logic [31:0] d);
    exp_t t;
    t = model(2'b01, d, 36'd0);
    return t.c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic [1:0] m, logic [31:0] d, logic [35:0] c);
    exp_t x;
    @(negedge clk);
    opMode = m; dataIn = d; chkIn = c;
    x = model(m, d, c);
    q.push_back(x);
    last = x;
  endtask

  task automatic idle(logic [1:0] code);
    @(negedge clk);
    opMode = code; dataIn = ~dataIn; chkIn = ~chkIn;
    @(negedge clk);
    check("R8 valid", {63'd0, validOut}, 64'd0);
    check("R8 flags", {62'd0, errFlag, uncFlag}, 64'd0);
    check("R8 data hold", {32'd0, dataOut}, {32'd0, last.d});
    check("R8 check hold", {28'd0, chkOut}, {28'd0, last.c});
  endtask

  // monitor: R9 latency, results compared one edge after issue
  always @(negedge clk) begin
    if (rstN && validOut) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: valid with no pending item, actual 1 expected 0");
      end else begin
        exp_t x;
        x = q.pop_front();
        check("R1/R4/R5 data", {32'd0, dataOut}, {32'd0, x.d});
        check("R1/R4 check", {28'd0, chkOut}, {28'd0, x.c});
        check("R2/R6/R7 err", {63'd0, errFlag}, {63'd0, x.e});
        check("R6 unc", {63'd0, uncFlag}, {63'd0, x.u});
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    a = 32'hA5C3_1E70;
    b = 32'h3C96_0F5A;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 outputs", {dataOut, 28'd0, validOut, errFlag, uncFlag, 1'b0},
          64'd0);
    check("R10 check", {28'd0, chkOut}, 64'd0);
    rstN = 1'b1;
    op(2'b01, a, 36'd0);                          // R1 R2 store
    op(2'b01, 32'hFFFF_FFFF, 36'd0);              // R1 carry into bit 4
    op(2'b10, a, gen(a));                         // R3 clean fetch
    op(2'b10, a ^ 32'h0000_0010, gen(a));         // R5 single bit row 0
    op(2'b10, a ^ 32'h0F00_0000, gen(a));         // R5 whole symbol row 1
    op(2'b10, b ^ 32'h0018_0000, gen(b));         // R5 burst across symbols
    op(2'b10, a ^ 32'h0002_0001, gen(a));         // R6 both rows flagged
    op(2'b10, a ^ 32'h0000_0202, gen(a));         // R6 sums cancel in row 0
    op(2'b10, a, gen(a) ^ 36'h1_0000_0000);       // R6 column check bit hit
    op(2'b10, a, gen(a) ^ 36'h0_0000_0400);       // R7 row check bit hit
    op(2'b10, a ^ 32'h0001_0001, gen(a));         // R7 same column both rows
    idle(2'b00);                                  // R8
    op(2'b10, b ^ 32'h8000_0000, gen(b));         // R4 syndromes, R5
    idle(2'b11);                                  // R8
    repeat (2) @(negedge clk);
    check("R9 queue drained", {32'd0, 32'(q.size())}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule